// File: doc/BRIEF.md
# Warp-Split Reconvergence Issue Gate

This block tracks the execution state of one 64-thread warp whose threads may sit at different program counters after divergent branches. Each cycle it receives every thread's PC together with a mask of the threads still alive. From these it forms the two most urgent warp-splits. The primary split is made up of the active threads that share the lowest PC. The secondary split is made up of the active threads that share the next distinct PC above it. The block reports both PCs and both thread masks, and lane i picks the primary or secondary instruction from bit i of those masks.

Two splits may issue in the same cycle, but a synchronization marker at the secondary split's PC limits that. The marker gives a divergence address, and its own PC serves as the reconvergence address. If the primary PC lies strictly between these two addresses, the secondary split is held. Otherwise it proceeds, so outer branches of a nested structure keep running in parallel. No release logic is needed. When the primary threads reach the held PC, the two PCs become equal and the threads form a single primary split. Every output is registered, so results appear one clock after the inputs that produce them.

Top module: `wsg_issue_gate`

## Requirements
- R1: `primary_pc` is the minimum PC over lanes whose `lane_active` bit is 1, and `primary_valid` is 1 exactly when at least one lane is active. When `primary_valid` is 0, `primary_pc` reads 0.
- R2: `secondary_pc` is the smallest active PC strictly greater than `primary_pc`. If no such PC exists, for example when all active threads share one PC, `secondary_valid` is 0 and `secondary_pc` reads 0.
- R3: Bit i of `primary_mask` (or `secondary_mask`) is 1 exactly when lane i is active and its PC, at bits [32*i+31:32*i] of `lane_pc`, equals the primary (or secondary) PC. The two masks never overlap, and lanes at any higher PC appear in neither.
- R4: `secondary_stall` is 1 when `secondary_valid` is 1, `sync_mark` is 1, and `sync_div_pc` < `primary_pc` < `secondary_pc`.
- R5: When `primary_pc` is less than or equal to `sync_div_pc`, `secondary_stall` is 0, including the case where the two are equal.
- R6: `secondary_stall` is 0 whenever `sync_mark` is 0 or `secondary_valid` is 0.
- R7: Once the primary threads reach the secondary PC, the threads at that PC form one primary split: `secondary_valid` is 0 (when no other PC exists) and `primary_mask` covers all of them.
- R8: All outputs are registered. Inputs presented before a rising clock edge appear on the outputs after that edge and not before it. While `rst_n` is low, every output is 0.
- R9: Inactive lanes are ignored, even when their PC is lower than every active PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_pc | input | 2048 | Per-thread PC, lane i at bits [32*i+31:32*i] |
| lane_active | input | 64 | 1 = thread i takes part in the search |
| sync_mark | input | 1 | Instruction at the current secondary PC is a synchronization marker |
| sync_div_pc | input | 32 | Divergence address carried by the marker |
| primary_valid | output | 1 | A primary split exists |
| primary_pc | output | 32 | Lowest active PC |
| primary_mask | output | 64 | Threads at the primary PC |
| secondary_valid | output | 1 | A secondary split exists |
| secondary_pc | output | 32 | Next distinct active PC |
| secondary_mask | output | 64 | Threads at the secondary PC |
| secondary_stall | output | 1 | Secondary split held at its marker |

## Verification
The assertions assume that `sync_mark` and `sync_div_pc` describe the instruction at the secondary PC computed from the same cycle's `lane_pc`. This lets a stall relate the registered PCs to the registered marker inputs without modelling instruction memory. The stimulus holds to that assumption: every directed case chooses the marker address with the secondary PC it creates in mind. The pseudo-random cases draw PCs from a small aligned set so that ties, single-PC warps and empty warps occur often. The stall rule is checked against whichever secondary PC results from each draw.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  parameter int unsigned WSG_LANES = 64;
  parameter int unsigned WSG_PC_W  = 32;

  typedef enum logic [1:0] {
    SPLIT_NONE = 2'd0,
    SPLIT_SOLO = 2'd1,
    SPLIT_PAIR = 2'd2
  } split_mode_e;
endpackage

// File: rtl/wsg_min_tree.sv
module wsg_min_tree #(
  parameter int unsigned N = 64,
  parameter int unsigned W = 32
) (
  input  logic [N*W-1:0] in_pc,
  input  logic [N-1:0]   in_ok,
  output logic [W-1:0]   out_pc,
  output logic           out_ok
);
  localparam int unsigned LVL = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned NP  = 1 << LVL;

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int unsigned CNT = NP >> l;
    logic [W-1:0] pc_q [CNT];
    logic         ok   [CNT];

    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_node
        if (j < N) begin : g_real
          assign pc_q[j] = in_pc[j*W +: W];
          assign ok[j]   = in_ok[j];
        end else begin : g_pad
          assign pc_q[j] = '0;
          assign ok[j]   = 1'b0;
        end
      end
    end else begin : g_inner
      for (genvar j = 0; j < CNT; j++) begin : g_node
        logic [W-1:0] a_pc, b_pc;
        logic         a_ok, b_ok, take_b;
        assign a_pc   = g_lvl[l-1].pc_q[2*j];
        assign b_pc   = g_lvl[l-1].pc_q[2*j+1];
        assign a_ok   = g_lvl[l-1].ok[2*j];
        assign b_ok   = g_lvl[l-1].ok[2*j+1];
        assign take_b = b_ok & (~a_ok | (b_pc < a_pc));
        assign pc_q[j] = take_b ? b_pc : a_pc;
        assign ok[j]   = a_ok | b_ok;
      end
    end
  end

  assign out_pc = g_lvl[LVL].pc_q[0];
  assign out_ok = g_lvl[LVL].ok[0];
endmodule

// File: rtl/wsg_mask_build.sv
module wsg_mask_build #(
  parameter int unsigned N = 64,
  parameter int unsigned W = 32
) (
  input  logic [N*W-1:0] lane_pc,
  input  logic [N-1:0]   lane_act,
  input  logic [W-1:0]   key_pc,
  input  logic           key_ok,
  output logic [N-1:0]   mask
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign mask[i] = key_ok & lane_act[i] & (lane_pc[i*W +: W] == key_pc);
  end
endmodule

// File: rtl/wsg_sync_gate.sv
module wsg_sync_gate #(
  parameter int unsigned W = 32
) (
  input  logic         sec_ok,
  input  logic         mark,
  input  logic [W-1:0] div_pc,
  input  logic [W-1:0] pri_pc,
  input  logic [W-1:0] sec_pc,
  output logic         hold
);
  logic above_div, below_rec;

  assign above_div = pri_pc > div_pc;
  assign below_rec = pri_pc < sec_pc;
  assign hold      = sec_ok & mark & above_div & below_rec;
endmodule

// File: rtl/wsg_issue_gate.sv
module wsg_issue_gate
  import wsg_pkg::*;
#(
  parameter int unsigned LANES = WSG_LANES,
  parameter int unsigned PC_W  = WSG_PC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES*PC_W-1:0] lane_pc,
  input  logic [LANES-1:0]      lane_active,
  input  logic                  sync_mark,
  input  logic [PC_W-1:0]       sync_div_pc,
  output logic                  primary_valid,
  output logic [PC_W-1:0]       primary_pc,
  output logic [LANES-1:0]      primary_mask,
  output logic                  secondary_valid,
  output logic [PC_W-1:0]       secondary_pc,
  output logic [LANES-1:0]      secondary_mask,
  output logic                  secondary_stall
);
  logic [PC_W-1:0]  min1_pc, min2_pc;
  logic             min1_ok, min2_ok;
  logic [LANES-1:0] pmask_d, smask_d, rest_act;
  logic             hold_d;
  split_mode_e      mode_d;

  logic             pv_d, sv_d;
  logic [PC_W-1:0]  ppc_d, spc_d;
  logic             upd_en;

  wsg_min_tree #(.N(LANES), .W(PC_W)) u_min_pri (
    .in_pc  (lane_pc),
    .in_ok  (lane_active),
    .out_pc (min1_pc),
    .out_ok (min1_ok)
  );

  wsg_mask_build #(.N(LANES), .W(PC_W)) u_mask_pri (
    .lane_pc  (lane_pc),
    .lane_act (lane_active),
    .key_pc   (min1_pc),
    .key_ok   (min1_ok),
    .mask     (pmask_d)
  );

  assign rest_act = lane_active & ~pmask_d;

  wsg_min_tree #(.N(LANES), .W(PC_W)) u_min_sec (
    .in_pc  (lane_pc),
    .in_ok  (rest_act),
    .out_pc (min2_pc),
    .out_ok (min2_ok)
  );

  wsg_mask_build #(.N(LANES), .W(PC_W)) u_mask_sec (
    .lane_pc  (lane_pc),
    .lane_act (rest_act),
    .key_pc   (min2_pc),
    .key_ok   (min2_ok),
    .mask     (smask_d)
  );

  wsg_sync_gate #(.W(PC_W)) u_gate (
    .sec_ok (min2_ok),
    .mark   (sync_mark),
    .div_pc (sync_div_pc),
    .pri_pc (min1_pc),
    .sec_pc (min2_pc),
    .hold   (hold_d)
  );

  // Next-state: classify the warp and zero the PCs of absent splits.
  always_comb begin
    if (!min1_ok)      mode_d = SPLIT_NONE;
    else if (min2_ok)  mode_d = SPLIT_PAIR;
    else               mode_d = SPLIT_SOLO;
    pv_d   = (mode_d != SPLIT_NONE);
    sv_d   = (mode_d == SPLIT_PAIR);
    ppc_d  = pv_d ? min1_pc : '0;
    spc_d  = sv_d ? min2_pc : '0;
    upd_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primary_valid   <= 1'b0;
      primary_pc      <= '0;
      primary_mask    <= '0;
      secondary_valid <= 1'b0;
      secondary_pc    <= '0;
      secondary_mask  <= '0;
      secondary_stall <= 1'b0;
    end else if (upd_en) begin
      primary_valid   <= pv_d;
      primary_pc      <= ppc_d;
      primary_mask    <= pmask_d;
      secondary_valid <= sv_d;
      secondary_pc    <= spc_d;
      secondary_mask  <= smask_d;
      secondary_stall <= hold_d;
    end
  end
endmodule

// File: rtl/wsg_issue_gate_chk.sv
module wsg_issue_gate_chk #(
  parameter int unsigned LANES = 64,
  parameter int unsigned PC_W  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LANES-1:0]      lane_active,
  input logic                  sync_mark,
  input logic                  primary_valid,
  input logic [PC_W-1:0]       primary_pc,
  input logic [LANES-1:0]      primary_mask,
  input logic                  secondary_valid,
  input logic [PC_W-1:0]       secondary_pc,
  input logic [LANES-1:0]      secondary_mask,
  input logic                  secondary_stall
);
  assert_masks_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primary_mask & secondary_mask) == '0);

  assert_masks_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((primary_mask | secondary_mask) & ~$past(lane_active)) == '0);

  assert_empty_warp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_active == '0) |=> (!primary_valid && !secondary_valid));

  assert_primary_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primary_valid == (primary_mask != '0));

  assert_sec_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    secondary_valid |-> (primary_valid && secondary_pc > primary_pc && secondary_mask != '0));

  assert_stall_needs_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    secondary_stall |-> secondary_valid);

  assert_stall_needs_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mark |=> !secondary_stall);
endmodule

bind wsg_issue_gate wsg_issue_gate_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .lane_active     (lane_active),
  .sync_mark       (sync_mark),
  .primary_valid   (primary_valid),
  .primary_pc      (primary_pc),
  .primary_mask    (primary_mask),
  .secondary_valid (secondary_valid),
  .secondary_pc    (secondary_pc),
  .secondary_mask  (secondary_mask),
  .secondary_stall (secondary_stall)
);

// File: tb/tb_wsg_issue_gate.sv
module tb_wsg_issue_gate;
  localparam int L = 64;
  localparam int W = 32;

  logic           clk, rst_n;
  logic [L*W-1:0] lane_pc;
  logic [L-1:0]   lane_active;
  logic           sync_mark;
  logic [W-1:0]   sync_div_pc;
  logic           primary_valid, secondary_valid, secondary_stall;
  logic [W-1:0]   primary_pc, secondary_pc;
  logic [L-1:0]   primary_mask, secondary_mask;

  wsg_issue_gate dut (
    .clk(clk), .rst_n(rst_n), .lane_pc(lane_pc), .lane_active(lane_active),
    .sync_mark(sync_mark), .sync_div_pc(sync_div_pc),
    .primary_valid(primary_valid), .primary_pc(primary_pc), .primary_mask(primary_mask),
    .secondary_valid(secondary_valid), .secondary_pc(secondary_pc),
    .secondary_mask(secondary_mask), .secondary_stall(secondary_stall)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [W-1:0] pcs [L];
  logic         e_pv, e_sv, e_st;
  logic [W-1:0] e_ppc, e_spc;
  logic [L-1:0] e_pm, e_sm;

  function automatic void pack_pcs();
    for (int i = 0; i < L; i++) lane_pc[i*W +: W] = pcs[i];
  endfunction

  // Expected outputs derived from the requirement text.
  function automatic void model();
    e_pv = 0; e_sv = 0; e_ppc = '0; e_spc = '0; e_pm = '0; e_sm = '0;
    for (int i = 0; i < L; i++)
      if (lane_active[i] && (!e_pv || pcs[i] < e_ppc)) begin e_pv = 1; e_ppc = pcs[i]; end
    for (int i = 0; i < L; i++)
      if (lane_active[i] && pcs[i] > e_ppc && (!e_sv || pcs[i] < e_spc)) begin e_sv = 1; e_spc = pcs[i]; end
    for (int i = 0; i < L; i++) begin
      e_pm[i] = e_pv && lane_active[i] && pcs[i] == e_ppc;
      e_sm[i] = e_sv && lane_active[i] && pcs[i] == e_spc;
    end
    e_st = e_sv && sync_mark && (sync_div_pc < e_ppc) && (e_ppc < e_spc);
  endfunction

  task automatic cmp(string req, string what, logic [L-1:0] act, logic [L-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp(req, "primary_valid",   L'(primary_valid),   L'(e_pv));
    cmp(req, "primary_pc",      L'(primary_pc),      L'(e_ppc));
    cmp(req, "primary_mask",    primary_mask,        e_pm);
    cmp(req, "secondary_valid", L'(secondary_valid), L'(e_sv));
    cmp(req, "secondary_pc",    L'(secondary_pc),    L'(e_spc));
    cmp(req, "secondary_mask",  secondary_mask,      e_sm);
    cmp(req, "secondary_stall", L'(secondary_stall), L'(e_st));
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
  task automatic apply(logic mark, logic [W-1:0] div, string req);
    @(negedge clk);
    pack_pcs();
    sync_mark = mark; sync_div_pc = div;
    model();
    @(negedge clk);
    check_all(req);
  endtask

  function automatic void fill(int lo, int hi, logic [W-1:0] pc);
    for (int i = lo; i <= hi; i++) pcs[i] = pc;
  endfunction

  task automatic t_reset();
    cmp("R8", "reset primary_valid", L'(primary_valid), '0);
    cmp("R8", "reset secondary_valid", L'(secondary_valid), '0);
    cmp("R8", "reset masks", primary_mask | secondary_mask, '0);
    cmp("R8", "reset stall", L'(secondary_stall), '0);
  endtask

  task automatic t_uniform();   // R2: single PC, no secondary split
    fill(0, L-1, 32'h40); lane_active = '1;
    apply(1'b1, 32'h10, "R2");
  endtask

  task automatic t_two_paths(); // R1 R3
    for (int i = 0; i < L; i++) pcs[i] = i[0] ? 32'h300 : 32'h280;
    lane_active = '1;
    apply(1'b0, 32'h0, "R3");
  endtask

  task automatic t_three_paths(); // R3: third PC in neither mask
    fill(0, 19, 32'h500); fill(20, 39, 32'h120); fill(40, 63, 32'h240);
    lane_active = '1;
    apply(1'b0, 32'h0, "R3");
  endtask

  task automatic t_inactive_low(); // R9
    fill(0, L-1, 32'h800); pcs[5] = 32'h4; pcs[60] = 32'h900;
    lane_active = '1; lane_active[5] = 1'b0;
    apply(1'b0, 32'h0, "R9");
  endtask

  task automatic t_empty(); // R1
    fill(0, L-1, 32'h20); lane_active = '0;
    apply(1'b1, 32'h0, "R1");
  endtask

  task automatic t_stall_window(); // R4 R5 R6
    fill(0, 31, 32'h100); fill(32, 63, 32'h200); lane_active = '1;
    apply(1'b1, 32'h080, "R4");
    cmp("R4", "stall inside window", L'(secondary_stall), L'(1));
    apply(1'b1, 32'h0F0, "R4");
    apply(1'b1, 32'h100, "R5");
    cmp("R5", "no stall at div equality", L'(secondary_stall), L'(0));
    apply(1'b1, 32'h180, "R5");
    apply(1'b0, 32'h080, "R6");
    cmp("R6", "no stall without marker", L'(secondary_stall), L'(0));
  endtask

  task automatic t_merge(); // R7
    fill(0, 31, 32'h100); fill(32, 63, 32'h140); lane_active = '1;
    apply(1'b1, 32'h0C0, "R7");
    fill(0, 31, 32'h140);
    apply(1'b1, 32'h0C0, "R7");
    cmp("R7", "merged mask", primary_mask, '1);
    cmp("R7", "merged secondary_valid", L'(secondary_valid), L'(0));
  endtask

  task automatic t_latency(); // R8
    logic [L-1:0] old_pm;
    fill(0, L-1, 32'h60); lane_active = '1;
    apply(1'b0, 32'h0, "R8");
    old_pm = primary_mask;
    @(negedge clk);
    fill(0, L-1, 32'h70); lane_active = 64'h0000_0000_FFFF_0000; pack_pcs();
    #5;
    cmp("R8", "mask held before edge", primary_mask, old_pm);
    cmp("R8", "pc held before edge", L'(primary_pc), L'(32'h60));
    model();
    @(negedge clk);
    check_all("R8");
  endtask

  task automatic t_random(); // R1 R2 R3 R4
    logic [31:0] s = 32'h1234_5678;
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < L; i++) begin
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        pcs[i] = 32'h1000 + ((s % 5) * 32'h20);
        lane_active[i] = (s[12:11] != 2'b00);
      end
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      apply(s[3], 32'h1000 + ((s[9:6] % 5) * 32'h20) - 32'h10, "R4");
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; lane_active = '0; sync_mark = 1'b0; sync_div_pc = '0; lane_pc = '0;
    for (int i = 0; i < L; i++) pcs[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_uniform();
    t_two_paths();
    t_three_paths();
    t_inactive_low();
    t_empty();
    t_stall_window();
    t_merge();
    t_latency();
    t_random();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule